// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers four interrupt sources for a small 8-bit processor core: an external pin, a timer overflow, an analog-to-digital end-of-conversion and a serial-bus event. The serial-bus event has two causes, an address match and the end of a byte. Each source has a sticky request flag and its own enable bit. All flags and enables sit in two byte-wide control registers that the core reads and writes. The core's register select chooses between them.

A master enable and a stack-full input gate all servicing. The core raises a phase strobe `tick` once per instruction slot. In a cycle where `tick` is high, the controller finds the most urgent source that is both pending and enabled. It raises a one-cycle acknowledge and presents that source's vector address in the same cycle. On the following clock edge it clears the flag it serviced and drops the master enable. The master enable comes back only through the return-from-interrupt strobe. A plain return strobe leaves it untouched.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both control registers read 0x00, `ack` is low and `vector` is 0x00.
- R2: Register 0 (`reg_sel`=0) holds master enable in bit 0. Bits 1, 2 and 3 are the external, timer and ADC enables. Bits 4, 5 and 6 are the external, timer and ADC flags. Bit 7 always reads 0.
- R3: Register 1 (`reg_sel`=1) holds the serial-bus enable in bit 0 and the serial-bus flag in bit 4. All other bits always read 0.
- R4: A one-cycle request pulse sets the matching flag on the next edge, and the flag stays set. The serial-bus flag is set by either `ser_addr_hit` or `ser_byte_done`.
- R5: `ack` is high only in a cycle where `tick` is high, the master enable is 1, `stack_full` is 0 and some flag is set together with its own enable.
- R6: When several sources qualify at once, the order is external, then timer, then ADC, then serial bus.
- R7: While `ack` is high, `vector` is 0x04 for external, 0x08 for timer, 0x0C for ADC and 0x10 for serial bus.
- R8: On the edge that ends an `ack` cycle, the serviced flag and the master enable clear. Other flags and all enables keep their values, so `ack` lasts exactly one cycle.
- R9: A `reti` pulse sets the master enable. A `ret` pulse leaves it unchanged.
- R10: A request pulse in the same cycle as a software write of 0 to that flag leaves the flag set.
- R11: A software write stores each flag and enable bit as written, so software can both clear and raise flags.
- R12: A request is only evaluated when its flag is already set in a `tick` cycle. A pulse that arrives in the `tick` cycle itself waits for the next `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Phase strobe; servicing is evaluated only while high |
| irq_ext | input | 1 | External interrupt request pulse |
| irq_tmr | input | 1 | Timer overflow request pulse |
| irq_adc | input | 1 | ADC end-of-conversion request pulse |
| ser_addr_hit | input | 1 | Serial-bus address match pulse |
| ser_byte_done | input | 1 | Serial-bus byte complete pulse |
| stack_full | input | 1 | Call stack has no free entry |
| reg_sel | input | 1 | Register select: 0 for register 0, 1 for register 1 |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Contents of the selected register |
| reti | input | 1 | Return-from-interrupt strobe |
| ret | input | 1 | Plain return strobe |
| ack | output | 1 | One-cycle interrupt acknowledge |
| vector | output | 8 | Vector address, valid while `ack` is high |

## Verification
The assertions assume that the core does not pulse `reti` in the same cycle as `ack`. A return only follows a serviced call, so this holds in normal use. The stimulus issues `reti` and `ret` only in cycles where `tick` is low, and it performs register writes only with `tick` low. As a result, no acknowledge can coincide with a return or with a write. Request pulses are driven for exactly one cycle. This keeps the flag-set checks, which look one edge ahead, tied to a single event.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NSRC = 4;
  localparam int IW   = $clog2(NSRC);

  typedef enum logic [IW-1:0] {
    SRC_EXT = 2'd0,
    SRC_TMR = 2'd1,
    SRC_ADC = 2'd2,
    SRC_SER = 2'd3
  } src_e;

  // vector address for a source slot: base plus slot times step
  function automatic logic [7:0] vec_of(input logic [IW-1:0] idx,
                                        input logic [7:0] base,
                                        input logic [7:0] step);
    logic [7:0] off;
    off = 8'(step * {{(8-IW){1'b0}}, idx});
    return 8'(base + off);
  endfunction

  // index of the single set bit of a one-hot grant
  function automatic logic [IW-1:0] idx_of(input logic [NSRC-1:0] g);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++)
      if (g[i]) r = IW'(i);
    return r;
  endfunction
endpackage

// File: rtl/ivc_flag_cell.sv
module ivc_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic ack_clr,
  input  logic sw_wr,
  input  logic sw_val,
  output logic q
);
  logic q_nx;

  // hardware set dominates, then service clear, then software write
  always_comb begin
    if (hw_set)       q_nx = 1'b1;
    else if (ack_clr) q_nx = 1'b0;
    else if (sw_wr)   q_nx = sw_val;
    else              q_nx = q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= 1'b0;
    else        q <= q_nx;
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] pend,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] above;

  assign above[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]    = pend[i] & ~above[i];
    assign above[i+1]  = above[i] | pend[i];
  end
  assign any = above[N];
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter logic [7:0] VEC_BASE = 8'h04,
  parameter logic [7:0] VEC_STEP = 8'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       irq_ext,
  input  logic       irq_tmr,
  input  logic       irq_adc,
  input  logic       ser_addr_hit,
  input  logic       ser_byte_done,
  input  logic       stack_full,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       reti,
  input  logic       ret,
  output logic       ack,
  output logic [7:0] vector
);
  import ivc_pkg::*;

  logic [NSRC-1:0] flag, en, pend, grant;
  logic [NSRC-1:0] set_vec, clr_vec, swwr_vec, swval_vec;
  logic            gie, any_pend, take_ok, wr0, wr1;
  logic [IW-1:0]   win_idx;

  assign wr0 = wr_en & ~reg_sel;
  assign wr1 = wr_en &  reg_sel;

  assign set_vec   = {ser_addr_hit | ser_byte_done, irq_adc, irq_tmr, irq_ext};
  assign swwr_vec  = {wr1, wr0, wr0, wr0};
  assign swval_vec = {wr_data[4], wr_data[6:4]};
  assign clr_vec   = grant & {NSRC{ack}};

  for (genvar s = 0; s < NSRC; s++) begin : g_flag
    ivc_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (set_vec[s]),
      .ack_clr(clr_vec[s]),
      .sw_wr  (swwr_vec[s]),
      .sw_val (swval_vec[s]),
      .q      (flag[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en <= '0;
    else begin
      if (wr0) en[2:0] <= wr_data[3:1];
      if (wr1) en[3]   <= wr_data[0];
    end

  // master enable: service clears, return-from-interrupt sets, else software
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    gie <= 1'b0;
    else if (ack)  gie <= 1'b0;
    else if (reti) gie <= 1'b1;
    else if (wr0)  gie <= wr_data[0];

  assign pend = flag & en;

  ivc_prio #(.N(NSRC)) u_prio (
    .pend (pend),
    .grant(grant),
    .any  (any_pend)
  );

  assign take_ok = tick & gie & ~stack_full;
  assign ack     = take_ok & any_pend;
  assign win_idx = idx_of(grant);
  assign vector  = ack ? vec_of(win_idx, VEC_BASE, VEC_STEP) : 8'h00;

  assign rd_data = reg_sel ? {3'b000, flag[3], 3'b000, en[3]}
                           : {1'b0, flag[2:0], en[2:0], gie};

  logic unused_ret;
  assign unused_ret = ret;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       stack_full,
  input logic       gie,
  input logic       ack,
  input logic       reti,
  input logic       irq_ext,
  input logic       irq_tmr,
  input logic       reg_sel,
  input logic [7:0] rd_data,
  input logic [3:0] pend,
  input logic [3:0] grant,
  input logic [3:0] flag
);
  a_r5_ack_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (tick && gie && !stack_full));

  a_r6_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ($countones(grant) == 1));

  a_r6_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pend[0]) |-> grant[0]);

  a_r8_gie_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !gie);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r8_tmr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && grant[1] && !irq_tmr) |=> !flag[1]);

  a_r9_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack) |=> gie);

  a_r4_ext_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ext |=> flag[0]);

  a_r2_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> !rd_data[7]);
endmodule

bind irq_vector_ctrl ivc_checker u_ivc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .stack_full(stack_full),
  .gie       (gie),
  .ack       (ack),
  .reti      (reti),
  .irq_ext   (irq_ext),
  .irq_tmr   (irq_tmr),
  .reg_sel   (reg_sel),
  .rd_data   (rd_data),
  .pend      (pend),
  .grant     (grant),
  .flag      (flag)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/100ps
module test_irq_vector_ctrl;
  logic clk = 0, rst_n = 0, tick = 0;
  logic irq_ext = 0, irq_tmr = 0, irq_adc = 0, ser_addr_hit = 0, ser_byte_done = 0;
  logic stack_full = 0, reg_sel = 0, wr_en = 0, reti = 0, ret = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data, vector;
  logic ack;
  int n_cmp = 0, n_bad = 0;
  logic done = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .irq_ext(irq_ext), .irq_tmr(irq_tmr),
    .irq_adc(irq_adc), .ser_addr_hit(ser_addr_hit), .ser_byte_done(ser_byte_done),
    .stack_full(stack_full), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .reti(reti), .ret(ret), .ack(ack), .vector(vector)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1;
    cyc();
    wr_en = 0;
  endtask

  task automatic rd_chk(input string tag, input logic sel, input logic [7:0] exp);
    reg_sel = sel; #0.3;
    chk(tag, rd_data, exp);
  endtask

  task automatic clear_all();
    wr(1, 8'h00); wr(0, 8'h00);
  endtask

  task automatic pulse_reti();
    reti = 1; cyc(); reti = 0;
  endtask

  task automatic t_reset();
    rd_chk("R1 reg0", 0, 8'h00);
    rd_chk("R1 reg1", 1, 8'h00);
    chk("R1 ack", {7'd0, ack}, 8'h00);
    chk("R1 vector", vector, 8'h00);
  endtask

  task automatic t_layout();
    wr(0, 8'hFF); rd_chk("R2 reg0 bit7", 0, 8'h7F);
    wr(1, 8'hFF); rd_chk("R3 reg1 spare bits", 1, 8'h11);
    clear_all();
    rd_chk("R11 reg0 cleared", 0, 8'h00);
    rd_chk("R11 reg1 cleared", 1, 8'h00);
  endtask

  task automatic t_sticky();
    irq_tmr = 1; cyc(); irq_tmr = 0;
    cyc(); cyc();
    rd_chk("R4 timer flag sticky", 0, 8'h20);
    ser_addr_hit = 1; cyc(); ser_addr_hit = 0;
    rd_chk("R4 serial addr hit", 1, 8'h10);
    clear_all();
    ser_byte_done = 1; cyc(); ser_byte_done = 0;
    cyc();
    rd_chk("R4 serial byte done", 1, 8'h10);
    clear_all();
  endtask

  task automatic t_gating();
    wr(0, 8'h24);
    tick = 1; #0.3; chk("R5 no ack master off", {7'd0, ack}, 8'h00); tick = 0;
    wr(0, 8'h21);
    tick = 1; #0.3; chk("R5 no ack source off", {7'd0, ack}, 8'h00); tick = 0;
    wr(0, 8'h25);
    stack_full = 1; tick = 1; #0.3;
    chk("R5 no ack stack full", {7'd0, ack}, 8'h00);
    stack_full = 0; tick = 0; #0.3;
    chk("R5 no ack without tick", {7'd0, ack}, 8'h00);
    tick = 1; #0.3;
    chk("R5 ack taken", {7'd0, ack}, 8'h01);
    chk("R7 timer vector", vector, 8'h08);
    cyc();
    chk("R8 ack one cycle", {7'd0, ack}, 8'h00);
    tick = 0;
    rd_chk("R8 flag and master cleared", 0, 8'h04);
    clear_all();
  endtask

  task automatic t_priority();
    wr(1, 8'h11); wr(0, 8'h7F);
    tick = 1; #0.3;
    chk("R6 ext wins", vector, 8'h04);
    cyc(); tick = 0;
    rd_chk("R8 others kept", 0, 8'h6E);
    pulse_reti();
    rd_chk("R9 reti sets master", 0, 8'h6F);
    tick = 1; #0.3; chk("R6 timer next", vector, 8'h08); cyc(); tick = 0;
    rd_chk("R8 after timer", 0, 8'h4E);
    pulse_reti();
    tick = 1; #0.3; chk("R6 adc next", vector, 8'h0C); cyc(); tick = 0;
    pulse_reti();
    tick = 1; #0.3; chk("R7 serial vector", vector, 8'h10); cyc(); tick = 0;
    rd_chk("R8 serial flag cleared", 1, 8'h01);
    rd_chk("R8 reg0 final", 0, 8'h0E);
    ret = 1; cyc(); ret = 0;
    rd_chk("R9 ret leaves master", 0, 8'h0E);
    pulse_reti();
    rd_chk("R9 reti after ret", 0, 8'h0F);
    clear_all();
  endtask

  task automatic t_race();
    irq_adc = 1; wr(0, 8'h00); irq_adc = 0;
    rd_chk("R10 set beats write 0", 0, 8'h40);
    wr(0, 8'h10);
    rd_chk("R11 software raises flag", 0, 8'h10);
    clear_all();
  endtask

  task automatic t_window();
    wr(0, 8'h03);
    tick = 1; irq_ext = 1; #0.3;
    chk("R12 same-cycle pulse waits", {7'd0, ack}, 8'h00);
    cyc(); irq_ext = 0; tick = 0; #0.3;
    chk("R12 no ack between ticks", {7'd0, ack}, 8'h00);
    rd_chk("R12 flag held", 0, 8'h13);
    cyc();
    tick = 1; #0.3;
    chk("R12 serviced on next tick", vector, 8'h04);
    cyc(); tick = 0;
    clear_all();
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    t_reset();
    rst_n = 1;
    cyc();
    t_layout();
    t_sticky();
    t_gating();
    t_priority();
    t_race();
    t_window();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule